// File: doc/BRIEF.md
# Banked DRAM Strobe and Lane Controller

This block drives the control pins of a DRAM array built from four banks. Each bank has four byte-wide lanes of 16K-deep devices. The block sits between an 8-bit or 16-bit processor bus and the array, and it runs synchronously to the bus clock.

An access begins in the cycle where both the active-low memory request and the active-low access qualifier are low. From that cycle on, the row strobe of the bank picked by the bank-select pair is driven low. A three-flop delay chain then times the rest of the access:

- The address multiplexer select moves to the column address one cycle after the start.
- The column strobe falls two cycles after that. It is one shared net for all banks, and only the bank whose row strobe is low responds.
- With the column strobe, the lane decoder pulls low an output-enable for a read or a write strobe for a write. It drives a single lane in byte mode, or a lane pair in word mode.

Refresh cycles come from the processor itself, so the block has no refresh arbiter. A refresh request with a memory request strobes the row of every bank at once and leaves everything else idle.

Top module: `dram_strobe_ctl`

## Requirements
- R1: While rst_n is low, all of ras_n, cas_n, oe_n and we_n are high (inactive) and mux_col is 0, whatever the bus inputs are.
- R2: An access exists while mreq_n=0, acc_n=0 and rfsh_n=1. During an access, ras_n[b] is low exactly for b equal to bank_sel, in the same cycle as the inputs. Every other ras_n bit stays high.
- R3: mux_col rises at the first clock edge after an access starts. cas_n falls at the third edge, which is two cycles after mux_col rises. cas_n is one shared output for all banks.
- R4: When the access condition goes away, mux_col, cas_n and all lane strobes are back to their inactive values after the next clock edge. An access that ends before the third edge never drives cas_n low.
- R5: While cas_n is low in an access, rd_wr=0 (read) drives the selected lane's oe_n bit low, and rd_wr=1 (write) drives the selected lane's we_n bit low. Lanes are numbered 0 to 3 (bit index = lane number).
- R6: An oe_n bit and a we_n bit are never low in the same cycle.
- R7: With wide16=0, only lane lane_sel is strobed. With wide16=1, lane_sel[0] is ignored: lanes 0 and 1 are strobed together when lane_sel[1]=0, and lanes 2 and 3 when lane_sel[1]=1.
- R8: During refresh (mreq_n=0 and rfsh_n=0), all four ras_n bits are low whatever acc_n is. cas_n, oe_n and we_n stay high, and mux_col stays 0.
- R9: If mreq_n or acc_n is high (and no refresh is requested), no ras_n bit is low and cas_n never falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; one delay stage per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| mreq_n | input | 1 | Active-low memory request |
| acc_n | input | 1 | Active-low access qualifier |
| rfsh_n | input | 1 | Active-low refresh cycle indicator |
| bank_sel | input | 2 | Bank chosen for the row strobe |
| lane_sel | input | 2 | Lane (byte mode) or lane pair in bit 1 (word mode) |
| rd_wr | input | 1 | 0 = read, 1 = write |
| wide16 | input | 1 | 1 = 16-bit word mode, 0 = byte mode |
| ras_n | output | 4 | Per-bank active-low row strobe |
| mux_col | output | 1 | Address multiplexer select, 1 = column address |
| cas_n | output | 1 | Shared active-low column strobe |
| oe_n | output | 4 | Per-lane active-low output enable |
| we_n | output | 4 | Per-lane active-low write strobe |

## Verification
The assertions check these rules on every cycle:

- At most one bank's row strobe is low, unless all four are low for a refresh.
- An output-enable and a write strobe never overlap.
- A lane strobe only appears while the column strobe is low.
- The column strobe only falls after the multiplexer has held the column address for two cycles and the access condition has been present for three.
- A refresh keeps the column strobe and all lane strobes idle.

Only the bench's scenarios show the exact decode, because the properties check patterns rather than values. That covers which bank and which lanes respond for a given select and direction, that word mode really ignores the low lane bit, the behaviour during reset, and that a shortened access ends without ever dropping the column strobe.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
   // Direction of a data transfer as seen on rd_wr
   typedef enum logic {
      XFER_READ  = 1'b0,
      XFER_WRITE = 1'b1
   } xfer_dir_e;

   // Bus qualifiers decoded once per cycle
   typedef struct packed {
      logic access;   // normal read/write cycle in progress
      logic refresh;  // processor-driven refresh cycle
   } bus_cycle_t;

   function automatic bus_cycle_t decode_cycle(input logic rst_n, input logic mreq_n,
                                               input logic acc_n, input logic rfsh_n);
      bus_cycle_t c;
      c.refresh = rst_n & ~mreq_n & ~rfsh_n;
      c.access  = rst_n & ~(mreq_n | acc_n) & rfsh_n;
      return c;
   endfunction
endpackage

// File: rtl/dsc_delay_chain.sv
module dsc_delay_chain #(
   parameter int DEPTH = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic [DEPTH-1:0] stage
);
   initial begin
      if (DEPTH < 2) $error("dsc_delay_chain: DEPTH must be at least 2");
   end

   // Each stage only stays set while the start condition persists,
   // so the whole chain clears one edge after start drops.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[0] <= 1'b0;
      else        stage[0] <= start;
   end

   for (genvar i = 1; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage[i] <= 1'b0;
         else        stage[i] <= stage[i-1] & start;
      end
   end
endmodule

// File: rtl/dsc_bank_decode.sv
module dsc_bank_decode #(
   parameter int N_BANKS = 4,
   localparam int BSEL_W = $clog2(N_BANKS)
) (
   input  logic              access,
   input  logic              refresh,
   input  logic [BSEL_W-1:0] bank_sel,
   output logic [N_BANKS-1:0] ras_n
);
   for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
      always_comb begin
         ras_n[b] = ~(refresh | (access & (bank_sel == BSEL_W'(b))));
      end
   end
endmodule

// File: rtl/dsc_lane_decode.sv
module dsc_lane_decode #(
   parameter int N_LANES      = 4,
   parameter bit SUPPORT_WIDE = 1'b1,
   localparam int LSEL_W = $clog2(N_LANES)
) (
   input  logic              fire,
   input  logic              rd_wr,
   input  logic              wide16,
   input  logic [LSEL_W-1:0] lane_sel,
   output logic [N_LANES-1:0] oe_n,
   output logic [N_LANES-1:0] we_n
);
   import dsc_pkg::*;

   logic [N_LANES-1:0] hit;
   logic               is_write;

   assign is_write = (xfer_dir_e'(rd_wr) == XFER_WRITE);

   for (genvar l = 0; l < N_LANES; l++) begin : g_lane
      if (SUPPORT_WIDE) begin : g_wide
         // Word mode compares only the pair index, dropping the low select bit
         always_comb begin
            if (wide16)
               hit[l] = (lane_sel[LSEL_W-1:1] == (LSEL_W-1)'(l >> 1));
            else
               hit[l] = (lane_sel == LSEL_W'(l));
         end
      end else begin : g_narrow
         logic unused_wide;
         assign unused_wide = wide16;
         always_comb hit[l] = (lane_sel == LSEL_W'(l));
      end

      always_comb begin
         oe_n[l] = ~(fire & hit[l] & ~is_write);
         we_n[l] = ~(fire & hit[l] &  is_write);
      end
   end
endmodule

// File: rtl/dram_strobe_ctl.sv
module dram_strobe_ctl #(
   parameter int N_BANKS      = 4,
   parameter int N_LANES      = 4,
   parameter int MUX_STAGE    = 1,
   parameter int CAS_STAGE    = 3,
   parameter bit SUPPORT_WIDE = 1'b1,
   localparam int BSEL_W = $clog2(N_BANKS),
   localparam int LSEL_W = $clog2(N_LANES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mreq_n,
   input  logic               acc_n,
   input  logic               rfsh_n,
   input  logic [BSEL_W-1:0]  bank_sel,
   input  logic [LSEL_W-1:0]  lane_sel,
   input  logic               rd_wr,
   input  logic               wide16,
   output logic [N_BANKS-1:0] ras_n,
   output logic               mux_col,
   output logic               cas_n,
   output logic [N_LANES-1:0] oe_n,
   output logic [N_LANES-1:0] we_n
);
   import dsc_pkg::*;

   initial begin
      if (N_BANKS < 2 || (1 << BSEL_W) != N_BANKS)
         $error("dram_strobe_ctl: N_BANKS must be a power of two >= 2");
      if (N_LANES < 2 || (1 << LSEL_W) != N_LANES)
         $error("dram_strobe_ctl: N_LANES must be a power of two >= 2");
      if (MUX_STAGE < 1 || MUX_STAGE >= CAS_STAGE)
         $error("dram_strobe_ctl: column select must switch before CAS");
   end

   bus_cycle_t         cyc;
   logic [CAS_STAGE-1:0] stage;

   assign cyc = decode_cycle(rst_n, mreq_n, acc_n, rfsh_n);

   dsc_delay_chain #(
      .DEPTH (CAS_STAGE)
   ) u_chain (
      .clk   (clk),
      .rst_n (rst_n),
      .start (cyc.access),
      .stage (stage)
   );

   assign mux_col = stage[MUX_STAGE-1];
   assign cas_n   = ~stage[CAS_STAGE-1];

   dsc_bank_decode #(
      .N_BANKS (N_BANKS)
   ) u_bank (
      .access   (cyc.access),
      .refresh  (cyc.refresh),
      .bank_sel (bank_sel),
      .ras_n    (ras_n)
   );

   dsc_lane_decode #(
      .N_LANES      (N_LANES),
      .SUPPORT_WIDE (SUPPORT_WIDE)
   ) u_lane (
      .fire     (stage[CAS_STAGE-1] & cyc.access),
      .rd_wr    (rd_wr),
      .wide16   (wide16),
      .lane_sel (lane_sel),
      .oe_n     (oe_n),
      .we_n     (we_n)
   );
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
   parameter int N_BANKS = 4,
   parameter int N_LANES = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               mreq_n,
   input logic               acc_n,
   input logic               rfsh_n,
   input logic [N_BANKS-1:0] ras_n,
   input logic               mux_col,
   input logic               cas_n,
   input logic [N_LANES-1:0] oe_n,
   input logic [N_LANES-1:0] we_n
);
   logic acc_c, rf_c, any_lane;
   assign acc_c    = !mreq_n && !acc_n && rfsh_n;
   assign rf_c     = !mreq_n && !rfsh_n;
   assign any_lane = (~oe_n != '0) || (~we_n != '0);

   AST_RAS_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_n == '0) || $onehot0(~ras_n)); // R2

   AST_CAS_AFTER_MUX: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n) |-> (mux_col && $past(mux_col) && $past(mux_col, 2))); // R3

   AST_DROP_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_c |=> (!mux_col && cas_n)); // R4

   AST_LANE_WITH_CAS: assert property (@(posedge clk) disable iff (!rst_n)
      any_lane |-> !cas_n); // R5

   AST_NO_OE_WE: assert property (@(posedge clk) disable iff (!rst_n)
      !((~oe_n != '0) && (~we_n != '0))); // R6

   AST_RFSH_ALL_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      rf_c |-> (ras_n == '0)); // R8

   AST_RFSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_c && $past(rf_c)) |-> (cas_n && !any_lane && !mux_col)); // R8

   AST_CAS_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n) |-> ($past(acc_c) && $past(acc_c, 2) && $past(acc_c, 3))); // R9
endmodule

bind dram_strobe_ctl dsc_checker #(
   .N_BANKS (N_BANKS),
   .N_LANES (N_LANES)
) u_dsc_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .mreq_n  (mreq_n),
   .acc_n   (acc_n),
   .rfsh_n  (rfsh_n),
   .ras_n   (ras_n),
   .mux_col (mux_col),
   .cas_n   (cas_n),
   .oe_n    (oe_n),
   .we_n    (we_n)
);

// File: tb/sim_dram_strobe_ctl.sv
module sim_dram_strobe_ctl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mreq_n = 1'b0, acc_n = 1'b0, rfsh_n = 1'b1;
   logic [1:0] bank_sel = 2'd0, lane_sel = 2'd0;
   logic       rd_wr = 1'b0, wide16 = 1'b0;
   logic [3:0] ras_n, oe_n, we_n;
   logic       mux_col, cas_n;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   dram_strobe_ctl u0 (
      .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .acc_n(acc_n), .rfsh_n(rfsh_n),
      .bank_sel(bank_sel), .lane_sel(lane_sel), .rd_wr(rd_wr), .wide16(wide16),
      .ras_n(ras_n), .mux_col(mux_col), .cas_n(cas_n), .oe_n(oe_n), .we_n(we_n)
   );

   // {wide16, rd_wr, lane_sel[1:0], bank_sel[1:0], exp_oe_n[3:0], exp_we_n[3:0]}
   localparam logic [13:0] VEC [0:7] = '{
      {1'b0, 1'b0, 2'd0, 2'd0, 4'b1110, 4'b1111},
      {1'b0, 1'b1, 2'd1, 2'd1, 4'b1111, 4'b1101},
      {1'b0, 1'b0, 2'd2, 2'd2, 4'b1011, 4'b1111},
      {1'b0, 1'b1, 2'd3, 2'd3, 4'b1111, 4'b0111},
      {1'b1, 1'b0, 2'd1, 2'd0, 4'b1100, 4'b1111},
      {1'b1, 1'b1, 2'd0, 2'd1, 4'b1111, 4'b1100},
      {1'b1, 1'b0, 2'd3, 2'd2, 4'b0011, 4'b1111},
      {1'b1, 1'b1, 2'd2, 2'd3, 4'b1111, 4'b0011}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle_bus();
      mreq_n = 1'b1; acc_n = 1'b1; rfsh_n = 1'b1;
   endtask

   task automatic expect_quiet(input string req);
      chk(req, {28'd0, ras_n}, 32'hF);
      chk(req, {31'd0, cas_n}, 32'd1);
      chk(req, {31'd0, mux_col}, 32'd0);
      chk(req, {24'd0, oe_n, we_n}, 32'hFF);
   endtask

   task automatic run_vec(input logic [13:0] v);
      logic [3:0] exp_ras;
      exp_ras = ~(4'b0001 << v[9:8]);
      @(negedge clk);
      wide16 = v[13]; rd_wr = v[12]; lane_sel = v[11:10]; bank_sel = v[9:8];
      mreq_n = 1'b0; acc_n = 1'b0; rfsh_n = 1'b1;
      #1;
      chk("R2 ras select", {28'd0, ras_n}, {28'd0, exp_ras});
      chk("R3 mux before edge", {31'd0, mux_col}, 32'd0);
      @(posedge clk); #1;
      chk("R3 mux after edge1", {31'd0, mux_col}, 32'd1);
      chk("R3 cas idle edge1", {31'd0, cas_n}, 32'd1);
      @(posedge clk); #1;
      chk("R3 cas idle edge2", {31'd0, cas_n}, 32'd1);
      @(posedge clk); #1;
      chk("R3 cas low edge3", {31'd0, cas_n}, 32'd0);
      chk("R5 R7 oe_n", {28'd0, oe_n}, {28'd0, v[7:4]});
      chk("R5 R7 we_n", {28'd0, we_n}, {28'd0, v[3:0]});
      chk("R2 ras held", {28'd0, ras_n}, {28'd0, exp_ras});
      @(negedge clk);
      idle_bus();
      @(posedge clk); #1;
      expect_quiet("R4 end of access");
   endtask

   initial begin
      // R1: active bus inputs during reset must not reach the outputs
      #1;
      expect_quiet("R1 reset");
      repeat (3) @(posedge clk);
      #1;
      expect_quiet("R1 reset held");
      @(negedge clk);
      idle_bus();
      rst_n = 1'b1;
      @(posedge clk); #1;
      expect_quiet("R1 after release");

      for (int i = 0; i < 8; i++) run_vec(VEC[i]);

      // R8: refresh with the access qualifier also low
      @(negedge clk);
      bank_sel = 2'd1; lane_sel = 2'd2; rd_wr = 1'b0; wide16 = 1'b0;
      mreq_n = 1'b0; acc_n = 1'b0; rfsh_n = 1'b0;
      #1;
      chk("R8 all ras", {28'd0, ras_n}, 32'd0);
      for (int k = 0; k < 4; k++) begin
         @(posedge clk); #1;
         chk("R8 cas idle", {31'd0, cas_n}, 32'd1);
         chk("R8 mux row", {31'd0, mux_col}, 32'd0);
         chk("R8 lanes idle", {24'd0, oe_n, we_n}, 32'hFF);
      end
      @(negedge clk); idle_bus();

      // R9: request without qualifier, then qualifier without request
      @(negedge clk);
      mreq_n = 1'b0; acc_n = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(posedge clk); #1;
         expect_quiet("R9 mreq only");
      end
      @(negedge clk);
      mreq_n = 1'b1; acc_n = 1'b0;
      for (int k = 0; k < 4; k++) begin
         @(posedge clk); #1;
         expect_quiet("R9 acc only");
      end
      @(negedge clk); idle_bus();

      // R4: access cut short after two edges never drops CAS
      @(negedge clk);
      bank_sel = 2'd3; lane_sel = 2'd0; rd_wr = 1'b1;
      mreq_n = 1'b0; acc_n = 1'b0;
      @(posedge clk); #1;
      @(posedge clk); #1;
      chk("R4 mux up before abort", {31'd0, mux_col}, 32'd1);
      @(negedge clk); idle_bus();
      @(posedge clk); #1;
      expect_quiet("R4 abort");
      @(posedge clk); #1;
      expect_quiet("R4 abort settled");

      // R6: flip direction while CAS is low; strobes swap, never overlap
      @(negedge clk);
      bank_sel = 2'd0; lane_sel = 2'd1; rd_wr = 1'b0; wide16 = 1'b0;
      mreq_n = 1'b0; acc_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R6 read side", {24'd0, oe_n, we_n}, 32'hDF);
      @(negedge clk); rd_wr = 1'b1;
      #1;
      chk("R6 write side", {24'd0, oe_n, we_n}, 32'hFD);
      @(negedge clk); idle_bus();
      @(posedge clk); #1;

      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule